// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This unit arbitrates five interrupt sources for a small 8-bit processor core. The five sources are:

- a non-maskable trap line;
- three maskable restart lines, named 7.5, 6.5 and 5.5;
- a general request line that carries no vector of its own.

The core pulses a strobe once per instruction, at the instruction boundary. On that strobe the unit picks the highest-priority eligible source. One cycle later it reports the source and its fixed 16-bit restart address. When the general request line wins, the unit instead drives an active-low acknowledge, so that the requesting device can supply the instruction.

Software controls the unit through two paths. A mask-write port sets three per-line mask bits and can also discard a remembered 7.5 edge. A global enable, set and cleared by two strobes, gates every source except the trap. The unit clears the global enable by itself whenever it accepts a maskable source. Instruction execution and the stack push are outside this unit.

The control is a three-state machine:

- **IDLE**: waits for the strobe.
- **VECTOR**: presents a restart address for one cycle.
- **ACK**: drives the acknowledge for one cycle.

There are four transitions:

- IDLE→VECTOR: the strobe arrives while the trap or a restart line wins.
- IDLE→ACK: the strobe arrives while the general line wins.
- VECTOR→IDLE and ACK→IDLE: taken unconditionally.

Top module: `vint_priority_unit`

## Requirements
- R1: With several sources eligible, the one taken follows the order trap, 7.5, 6.5, 5.5, general. The source code on `src_o` is 1 trap, 2 line 7.5, 3 line 6.5, 4 line 5.5, 5 general, and 0 when nothing is taken.
- R2: `vector_o` gives 0x0024 for trap, 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5. It gives 0x0000 for the general line and when nothing is taken.
- R3: The trap is taken whatever the mask bits and the global enable hold.
- R4: The trap is taken only if a rising edge was seen on the trap line and the line is still high at the strobe. Holding the line high after a trap has been taken does not cause it to be taken again.
- R5: A rising edge on line 7.5 is remembered, even while 7.5 is masked. It stays remembered until 7.5 is taken or until a mask write with `mask_wdata_i[3]`=1 discards it.
- R6: Line 6.5 and line 5.5 are level-sensitive. The mask bits are `mask_wdata_i[0]` for 5.5, `[1]` for 6.5 and `[2]` for 7.5. A bit value of 1 masks the line, and a masked line is never taken.
- R7: When `ien_o`=0, no source other than the trap is taken. `ien_set_i` sets the enable, and `ien_clr_i` or the acceptance of any maskable source (codes 2 to 5) clears it.
- R8: A source is accepted only on a cycle where `sample_i`=1 and the unit is idle. `take_o`, `src_o` and `vector_o` show the result in the following cycle, for exactly one cycle.
- R9: When the general line is taken, `inta_n_o` is 0 for exactly that one result cycle. It is 1 at all other times.
- R10: After reset, `take_o`=0, `inta_n_o`=1, `ien_o`=0, `src_o`=0, `vector_o`=0, and all three lines are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Instruction-boundary strobe |
| trap_i | input | 1 | Non-maskable trap line |
| rst75_i | input | 1 | Edge-latched restart line 7.5 |
| rst65_i | input | 1 | Level restart line 6.5 |
| rst55_i | input | 1 | Level restart line 5.5 |
| intr_i | input | 1 | General request line without a vector |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 4 | [2:0] mask bits for 7.5/6.5/5.5, [3] discard the 7.5 edge |
| ien_set_i | input | 1 | Set the global enable |
| ien_clr_i | input | 1 | Clear the global enable |
| take_o | output | 1 | One-cycle pulse when a source is taken |
| src_o | output | 3 | Code of the source taken |
| vector_o | output | 16 | Restart address of the source taken |
| inta_n_o | output | 1 | Active-low acknowledge for the general line |
| ien_o | output | 1 | Global enable state |

## Verification
The bench aims at the cases where a plausible mistake changes which source wins.

- **Trap line held high.** A trap detector that looks at the level instead of the edge would take the trap a second time.
- **Short trap pulse.** If the pulse falls before the strobe, a design that ignored the level at the strobe would take it anyway.
- **7.5 edge handling.** A short 7.5 pulse must be remembered even while the line is masked, and a mask write must be able to discard it. An unlatched 7.5 would miss the short pulse, and a design without the discard bit would take a stale edge.
- **Strobe and enable.** A design that arbitrated without the strobe would fire early, and one that kept the enable set after acceptance would allow nested maskable takes.
- **Acknowledge width.** The bench checks that the acknowledge lasts exactly one cycle.

// File: rtl/vint_pkg.sv
package vint_pkg;

    localparam int NSRC  = 5;
    localparam int VEC_W = 16;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_INTR = 3'd5
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_VECTOR = 2'd1,
        ST_ACK    = 2'd2
    } st_e;

    // Request index i (0 = highest priority) to source code
    function automatic src_e src_of_idx(input int idx);
        case (idx)
            0:       return SRC_TRAP;
            1:       return SRC_R75;
            2:       return SRC_R65;
            3:       return SRC_R55;
            4:       return SRC_INTR;
            default: return SRC_NONE;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input src_e s);
        case (s)
            SRC_TRAP: return VEC_W'(16'h0024);
            SRC_R75:  return VEC_W'(16'h003C);
            SRC_R65:  return VEC_W'(16'h0034);
            SRC_R55:  return VEC_W'(16'h002C);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/vint_rise_latch.sv
// Remembers a rising edge on a line until cleared; a new edge wins over clear.
module vint_rise_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = level_i & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= level_i;
            if (rise)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R5: an edge always leaves the latch set
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (level_i && !prev_q) |=> pend_q);

endmodule

// File: rtl/vint_capture.sv
module vint_capture
    import vint_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int MASK_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_i,
    input  logic             rst75_i,
    input  logic             rst65_i,
    input  logic             rst55_i,
    input  logic             intr_i,
    input  logic             mask_wr_i,
    input  logic [MASK_W:0]  mask_wdata_i,
    input  logic             ien_set_i,
    input  logic             ien_clr_i,
    input  logic             accept_i,
    input  src_e             accept_src_i,
    output logic [N_SRC-1:0] req_o,
    output logic             ien_o
);
    localparam int M55 = 0;
    localparam int M65 = 1;
    localparam int M75 = 2;
    localparam int CLR_BIT = MASK_W;

    logic [MASK_W-1:0] mask_q;
    logic              ien_q;
    logic              trap_pend;
    logic              r75_pend;
    logic              trap_clr;
    logic              r75_clr;
    logic              maskable_take;

    assign trap_clr      = accept_i && (accept_src_i == SRC_TRAP);
    assign r75_clr       = (accept_i && (accept_src_i == SRC_R75)) ||
                           (mask_wr_i && mask_wdata_i[CLR_BIT]);
    assign maskable_take = accept_i && (accept_src_i != SRC_TRAP) &&
                           (accept_src_i != SRC_NONE);

    vint_rise_latch u_trap_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(trap_i),
        .clr_i  (trap_clr),
        .pend_o (trap_pend)
    );

    vint_rise_latch u_r75_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(rst75_i),
        .clr_i  (r75_clr),
        .pend_o (r75_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            ien_q  <= 1'b0;
        end else begin
            if (mask_wr_i)
                mask_q <= mask_wdata_i[MASK_W-1:0];
            if (maskable_take)
                ien_q <= 1'b0;
            else if (ien_clr_i)
                ien_q <= 1'b0;
            else if (ien_set_i)
                ien_q <= 1'b1;
        end
    end

    always_comb begin
        req_o    = '0;
        req_o[0] = trap_pend & trap_i;
        req_o[1] = r75_pend & ~mask_q[M75] & ien_q;
        req_o[2] = rst65_i  & ~mask_q[M65] & ien_q;
        req_o[3] = rst55_i  & ~mask_q[M55] & ien_q;
        req_o[4] = intr_i   & ien_q;
    end

    assign ien_o = ien_q;

    // R7: accepting a maskable source drops the global enable
    a_r7_ien_drop: assert property (@(posedge clk) disable iff (!rst_n)
        maskable_take |=> !ien_q);

    // R7: with the enable off only the trap can request
    a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> (req_o[N_SRC-1:1] == '0));

endmodule

// File: rtl/vint_resolver.sv
module vint_resolver
    import vint_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output src_e             win_o
);
    logic [N_SRC:0]   blocked;
    logic [N_SRC-1:0] grant;

    assign blocked[0] = 1'b0;

    for (genvar i = 0; i < N_SRC; i++) begin : g_chain
        assign grant[i]     = req_i[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | req_i[i];
    end

    always_comb begin
        win_o = SRC_NONE;
        for (int i = 0; i < N_SRC; i++)
            if (grant[i])
                win_o = src_of_idx(i);
    end

    assign any_o = blocked[N_SRC];

    // R1: never more than one winner
    a_r1_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R1: the top-priority request always wins
    a_r1_trap_top: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[0] |-> (win_o == SRC_TRAP));

endmodule

// File: rtl/vint_fsm.sv
module vint_fsm
    import vint_pkg::*;
#(
    parameter int V_W = VEC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sample_i,
    input  logic           any_i,
    input  src_e           win_i,
    output logic           accept_o,
    output logic           take_o,
    output logic           inta_n_o,
    output src_e           src_o,
    output logic [V_W-1:0] vector_o
);
    st_e            state_q;
    st_e            state_d;
    src_e           src_q;
    logic [V_W-1:0] vec_q;

    assign accept_o = (state_q == ST_IDLE) && sample_i && any_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_o)
                    state_d = (win_i == SRC_INTR) ? ST_ACK : ST_VECTOR;
            end
            ST_VECTOR: state_d = ST_IDLE;
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_NONE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                src_q <= win_i;
                vec_q <= vec_of(win_i);
            end
        end
    end

    always_comb begin
        take_o   = 1'b0;
        inta_n_o = 1'b1;
        src_o    = SRC_NONE;
        vector_o = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VECTOR: begin
                take_o   = 1'b1;
                src_o    = src_q;
                vector_o = vec_q;
            end
            ST_ACK: begin
                take_o   = 1'b1;
                inta_n_o = 1'b0;
                src_o    = src_q;
            end
            default: ;
        endcase
    end

    // R8: result lasts one cycle
    a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R8: no strobe, no acceptance
    a_r8_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sample_i) |=> !take_o);

    // R9: acknowledge only for the general line, one cycle wide
    a_r9_ack_src: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |-> (src_o == SRC_INTR));
    a_r9_ack_width: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |=> inta_n_o);

endmodule

// File: rtl/vint_priority_unit.sv
module vint_priority_unit
    import vint_pkg::*;
#(
    parameter int V_W    = VEC_W,
    parameter int N_SRC  = NSRC,
    parameter int MASK_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_i,
    input  logic            trap_i,
    input  logic            rst75_i,
    input  logic            rst65_i,
    input  logic            rst55_i,
    input  logic            intr_i,
    input  logic            mask_wr_i,
    input  logic [MASK_W:0] mask_wdata_i,
    input  logic            ien_set_i,
    input  logic            ien_clr_i,
    output logic            take_o,
    output logic [2:0]      src_o,
    output logic [V_W-1:0]  vector_o,
    output logic            inta_n_o,
    output logic            ien_o
);
    logic [N_SRC-1:0] req;
    logic             any;
    src_e             win;
    logic             accept;
    src_e             src_e_o;

    vint_capture #(.N_SRC(N_SRC), .MASK_W(MASK_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_i      (trap_i),
        .rst75_i     (rst75_i),
        .rst65_i     (rst65_i),
        .rst55_i     (rst55_i),
        .intr_i      (intr_i),
        .mask_wr_i   (mask_wr_i),
        .mask_wdata_i(mask_wdata_i),
        .ien_set_i   (ien_set_i),
        .ien_clr_i   (ien_clr_i),
        .accept_i    (accept),
        .accept_src_i(win),
        .req_o       (req),
        .ien_o       (ien_o)
    );

    vint_resolver #(.N_SRC(N_SRC)) u_resolver (
        .clk  (clk),
        .rst_n(rst_n),
        .req_i(req),
        .any_o(any),
        .win_o(win)
    );

    vint_fsm #(.V_W(V_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(sample_i),
        .any_i   (any),
        .win_i   (win),
        .accept_o(accept),
        .take_o  (take_o),
        .inta_n_o(inta_n_o),
        .src_o   (src_e_o),
        .vector_o(vector_o)
    );

    assign src_o = src_e_o;

    // R3: an accepted trap request is reported as trap next cycle
    a_r3_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req[0]) |=> (take_o && src_o == 3'd1));

    // R2: trap result carries its restart address
    a_r2_trap_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && src_o == 3'd1) |-> (vector_o == V_W'(16'h0024)));

endmodule

// File: tb/test_vint_priority_unit.sv
`timescale 1ns/1ps
module test_vint_priority_unit;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_i = 0, trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, intr_i = 0;
    logic        mask_wr_i = 0, ien_set_i = 0, ien_clr_i = 0;
    logic [3:0]  mask_wdata_i = 0;
    logic        take_o, inta_n_o, ien_o;
    logic [2:0]  src_o;
    logic [15:0] vector_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    vint_priority_unit i_vint_priority_unit (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .trap_i(trap_i),
        .rst75_i(rst75_i), .rst65_i(rst65_i), .rst55_i(rst55_i), .intr_i(intr_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
        .take_o(take_o), .src_o(src_o), .vector_o(vector_o),
        .inta_n_o(inta_n_o), .ien_o(ien_o)
    );

    // {ien, mask[2:0]=(7.5,6.5,5.5), lines[4:0]=(trap,7.5,6.5,5.5,general), expected src}
    localparam logic [11:0] TAB [0:11] = '{
        {1'b1, 3'b000, 5'b00010, 3'd4},
        {1'b1, 3'b000, 5'b00110, 3'd3},
        {1'b1, 3'b000, 5'b01111, 3'd2},
        {1'b1, 3'b000, 5'b11111, 3'd1},
        {1'b1, 3'b000, 5'b00001, 3'd5},
        {1'b1, 3'b111, 5'b01110, 3'd0},
        {1'b1, 3'b100, 5'b01100, 3'd3},
        {1'b0, 3'b000, 5'b00100, 3'd0},
        {1'b0, 3'b111, 5'b10000, 3'd1},
        {1'b1, 3'b001, 5'b00011, 3'd5},
        {1'b1, 3'b010, 5'b00110, 3'd4},
        {1'b0, 3'b000, 5'b00001, 3'd0}
    };

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd1: return 16'h0024;
            3'd2: return 16'h003C;
            3'd3: return 16'h0034;
            3'd4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // strobe for one cycle; on return the result cycle is visible
    task automatic strobe();
        @(negedge clk); sample_i = 1'b1;
        @(negedge clk); sample_i = 1'b0;
    endtask

    task automatic mask_write(input logic [3:0] d);
        @(negedge clk); mask_wr_i = 1'b1; mask_wdata_i = d;
        @(negedge clk); mask_wr_i = 1'b0;
    endtask

    task automatic enable(input logic on);
        @(negedge clk); ien_set_i = on; ien_clr_i = !on;
        @(negedge clk); ien_set_i = 1'b0; ien_clr_i = 1'b0;
    endtask

    task automatic lines_off();
        trap_i = 0; rst75_i = 0; rst65_i = 0; rst55_i = 0; intr_i = 0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 take", take_o, 0);
        chk("R10 inta_n", inta_n_o, 1);
        chk("R10 ien", ien_o, 0);
        chk("R10 src", src_o, 0);
        chk("R10 vector", vector_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: all masked after reset; enable on, level 5.5 high, must not be taken
        enable(1'b1);
        rst55_i = 1'b1;
        strobe();
        chk("R10 masked after reset", take_o, 0);
        rst55_i = 1'b0;

        // table walk: R1 R2 R3 R6 R7 R9
        for (int k = 0; k < 12; k++) begin
            logic [11:0] e;
            logic [2:0]  es;
            e  = TAB[k];
            es = e[2:0];
            @(negedge clk);
            ien_set_i = e[11]; ien_clr_i = !e[11];
            mask_wr_i = 1'b1; mask_wdata_i = {1'b1, e[10:8]};
            {trap_i, rst75_i, rst65_i, rst55_i, intr_i} = e[7:3];
            @(negedge clk);
            ien_set_i = 0; ien_clr_i = 0; mask_wr_i = 0;
            sample_i = 1'b1;
            @(negedge clk);
            sample_i = 1'b0;
            chk($sformatf("R1 take row %0d", k), take_o, (es != 0));
            chk($sformatf("R1 src row %0d", k), src_o, es);
            chk($sformatf("R2 vector row %0d", k), vector_o, exp_vec(es));
            chk($sformatf("R9 inta_n row %0d", k), inta_n_o, (es != 3'd5));
            chk($sformatf("R7 ien row %0d", k), ien_o,
                (es >= 3'd2) ? 1'b0 : e[11]);
            @(negedge clk);
            if (es == 3'd5) chk("R9 ack one cycle", inta_n_o, 1);
            chk($sformatf("R8 single pulse row %0d", k), take_o, 0);
            lines_off();
            mask_write(4'b1111);
        end

        // R8: no strobe, no take
        mask_write(4'b1000);
        enable(1'b1);
        rst55_i = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R8 no strobe", take_o, 0);
        end
        strobe();
        chk("R8 taken at strobe", src_o, 3'd4);
        rst55_i = 1'b0;

        // R4: held trap not retaken
        @(negedge clk); trap_i = 1'b1;
        strobe();
        chk("R4 trap first", src_o, 3'd1);
        repeat (3) @(negedge clk);
        strobe();
        chk("R4 held trap not retaken", take_o, 0);
        trap_i = 1'b0;

        // R4: trap pulse gone before strobe
        @(negedge clk); trap_i = 1'b1;
        @(negedge clk); trap_i = 1'b0;
        strobe();
        chk("R4 dropped trap", take_o, 0);

        // R5: short 7.5 pulse remembered, then consumed
        mask_write(4'b1000);
        enable(1'b1);
        @(negedge clk); rst75_i = 1'b1;
        @(negedge clk); rst75_i = 1'b0;
        repeat (2) @(negedge clk);
        strobe();
        chk("R5 latched 7.5 taken", src_o, 3'd2);
        enable(1'b1);
        strobe();
        chk("R5 latch consumed", take_o, 0);

        // R5: discard via mask write
        @(negedge clk); rst75_i = 1'b1;
        @(negedge clk); rst75_i = 1'b0;
        mask_write(4'b1000);
        strobe();
        chk("R5 discarded edge", take_o, 0);

        // R5 R6: edge remembered while masked, taken after unmask
        mask_write(4'b0100);
        @(negedge clk); rst75_i = 1'b1;
        @(negedge clk); rst75_i = 1'b0;
        strobe();
        chk("R6 masked 7.5 not taken", take_o, 0);
        mask_write(4'b0000);
        strobe();
        chk("R5 edge kept through mask", src_o, 3'd2);
        chk("R7 ien after 7.5", ien_o, 0);

        // R7: clear strobe blocks general line
        enable(1'b1);
        enable(1'b0);
        intr_i = 1'b1;
        strobe();
        chk("R7 cleared enable", take_o, 0);
        intr_i = 1'b0;

        summary();
        $finish;
    end

endmodule